// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers every reset request of a chip into one chip reset. The requests are a power-on pulse, a brown-out level, a debounced active-low external reset pin and a watchdog timeout. Once the last request has gone away, the chip reset is held through two timed waits before it is released. The first is a power-up wait counted on a slow watchdog-oscillator clock. The second is an oscillator-settle wait counted on the main clock. Each wait can be switched off.

The block also keeps a sleep state. A watchdog timeout that arrives while asleep wakes the chip and does not reset it. Two status flags (timeout, power-down) and a three-bit cause code are written at each event, so software can tell the six reset kinds apart. The kinds are power-on, brown-out, watchdog while running, watchdog wake from sleep, pin while running and pin while asleep. The power-on input is the block's own asynchronous reset. The slow clock is brought into the main clock domain and used as a tick.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_i` is high, and after it falls until the sequence completes, `chip_rst_o` is 1; power-on leaves `to_flag_o`=1, `pd_flag_o`=1 and `rst_cause_o`=1.
- R2: A brown-out (`bor_detect_i`=1 with `bor_en_i`=1) asserts `chip_rst_o` one cycle later and sets `to_flag_o`=1, `pd_flag_o`=1 and `rst_cause_o`=2; with `bor_en_i`=0 the detect level changes nothing.
- R3: With `ext_rst_en_i`=1, a low level on `ext_rst_n_i` is a reset request only once it has held for FILT_LEN (4) consecutive sampled cycles; shorter low pulses, and any pulse while `ext_rst_en_i`=0, produce no reset.
- R4: A pin reset while running sets `rst_cause_o`=5 and leaves both flags unchanged.
- R5: A pin reset while asleep sets `rst_cause_o`=6 and clears `pd_flag_o`, leaving `to_flag_o` unchanged.
- R6: A watchdog timeout while running asserts `chip_rst_o` one cycle later, clears `to_flag_o`, leaves `pd_flag_o` unchanged and sets `rst_cause_o`=3.
- R7: A watchdog timeout while asleep never asserts `chip_rst_o`; it ends sleep and clears both flags, with `rst_cause_o`=4.
- R8: A `sleep_enter_i` pulse while `chip_rst_o`=0 and no request is active enters sleep, setting `to_flag_o`=1 and clearing `pd_flag_o`; while `chip_rst_o`=1 the pulse is ignored.
- R9: `chip_rst_o` stays 1 while any request is active. After the last request ends, it falls after 1 cycle, plus 2^PWRT_W rising edges of the slow clock when `pwrt_en_i`=1, plus 2^OST_W main-clock cycles when `ost_en_i`=1, with the power-up wait before the oscillator wait.
- R10: A new request during either wait restarts the whole sequence, so both waits run again in full.
- R11: Any chip reset request ends the sleep state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Main oscillator clock |
| wdt_osc_clk_i | input | 1 | Slow watchdog-oscillator clock, asynchronous |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| bor_detect_i | input | 1 | Brown-out detect level, active high |
| bor_en_i | input | 1 | Enable for brown-out reset |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| ext_rst_en_i | input | 1 | Enable for the external pin reset |
| wdt_timeout_i | input | 1 | Watchdog timeout pulse |
| sleep_enter_i | input | 1 | Request to enter sleep |
| pwrt_en_i | input | 1 | Enable for the power-up wait |
| ost_en_i | input | 1 | Enable for the oscillator-settle wait |
| chip_rst_o | output | 1 | Chip reset, active high |
| to_flag_o | output | 1 | Timeout status flag |
| pd_flag_o | output | 1 | Power-down status flag |
| rst_cause_o | output | 3 | Last event code (1 power-on, 2 brown-out, 3 watchdog run, 4 watchdog wake, 5 pin run, 6 pin sleep) |

## Verification
The bench sweeps the pin pulse length across the filter threshold. A filter one count short would reset on a three-cycle glitch, and one count long would miss a four-cycle press. It tries all four wait-enable combinations and fires a second request partway through the oscillator wait. A chain that skipped a stage, swapped the order or resumed a half-done count would release reset early. It drives the watchdog both asleep and awake, and a pin press while asleep. A design that mixed these up would reset on a wake, report the wrong cause, or stay asleep after a pin reset, so that the next watchdog timeout would be taken as a wake.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_POWER_ON  = 3'd1,
        CAUSE_BROWNOUT  = 3'd2,
        CAUSE_WDOG_RUN  = 3'd3,
        CAUSE_WDOG_WAKE = 3'd4,
        CAUSE_PIN_RUN   = 3'd5,
        CAUSE_PIN_SLEEP = 3'd6
    } rst_cause_e;

    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,
        SEQ_PWRUP = 2'd1,
        SEQ_OSCST = 2'd2,
        SEQ_RUN   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic din_i,
    output logic dout_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = din_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], din_i};
        end
    endgenerate

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout_o = sh_q[STAGES-1];
endmodule

// File: rtl/rsq_pin_filter.sv
module rsq_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic pin_n_i,
    output logic held_low_o
);
    localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          active;
    } filt_t;

    filt_t cur_q, nxt_d;
    logic  pin_s;

    rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk_i (clk_i),
        .arst_i(arst_i),
        .din_i (pin_n_i),
        .dout_o(pin_s)
    );

    always_comb begin
        nxt_d = cur_q;
        if (!pin_s) begin
            if (cur_q.cnt == LAST) nxt_d.active = 1'b1;
            else                   nxt_d.cnt    = cur_q.cnt + CW'(1);
        end else begin
            nxt_d.cnt    = '0;
            nxt_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign held_low_o = cur_q.active;
endmodule

// File: rtl/rsq_tick_sync.sv
module rsq_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic slow_clk_i,
    output logic tick_o
);
    logic slow_s;
    logic prev_d, prev_q;

    rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_slow_sync (
        .clk_i (clk_i),
        .arst_i(arst_i),
        .din_i (slow_clk_i),
        .dout_o(slow_s)
    );

    always_comb prev_d = slow_s;

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign tick_o = slow_s & ~prev_q;
endmodule

// File: rtl/rsq_timer_chain.sv
module rsq_timer_chain
    import rsq_pkg::*;
#(
    parameter int PWRT_W = 11,
    parameter int OST_W  = 10
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic req_i,
    input  logic slow_tick_i,
    input  logic pwrt_en_i,
    input  logic ost_en_i,
    output logic chip_rst_o
);
    localparam int CNT_W = (PWRT_W > OST_W) ? PWRT_W : OST_W;
    localparam logic [CNT_W-1:0] PW_LAST = CNT_W'((2 ** PWRT_W) - 1);
    localparam logic [CNT_W-1:0] OS_LAST = CNT_W'((2 ** OST_W) - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } chain_t;

    chain_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (req_i) begin
            nxt_d.st  = SEQ_HOLD;
            nxt_d.cnt = '0;
        end else begin
            case (cur_q.st)
                SEQ_HOLD: begin
                    nxt_d.cnt = '0;
                    if (pwrt_en_i)     nxt_d.st = SEQ_PWRUP;
                    else if (ost_en_i) nxt_d.st = SEQ_OSCST;
                    else               nxt_d.st = SEQ_RUN;
                end
                SEQ_PWRUP: begin
                    if (slow_tick_i) begin
                        if (cur_q.cnt == PW_LAST) begin
                            nxt_d.cnt = '0;
                            nxt_d.st  = ost_en_i ? SEQ_OSCST : SEQ_RUN;
                        end else begin
                            nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                        end
                    end
                end
                SEQ_OSCST: begin
                    if (cur_q.cnt == OS_LAST) begin
                        nxt_d.cnt = '0;
                        nxt_d.st  = SEQ_RUN;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                    end
                end
                default: nxt_d = cur_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            cur_q.st  <= SEQ_HOLD;
            cur_q.cnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign chip_rst_o = (cur_q.st != SEQ_RUN);
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rsq_pkg::*;
#(
    parameter int PWRT_W      = 11,
    parameter int OST_W       = 10,
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       osc_clk_i,
    input  logic       wdt_osc_clk_i,
    input  logic       por_i,
    input  logic       bor_detect_i,
    input  logic       bor_en_i,
    input  logic       ext_rst_n_i,
    input  logic       ext_rst_en_i,
    input  logic       wdt_timeout_i,
    input  logic       sleep_enter_i,
    input  logic       pwrt_en_i,
    input  logic       ost_en_i,
    output logic       chip_rst_o,
    output logic       to_flag_o,
    output logic       pd_flag_o,
    output logic [2:0] rst_cause_o
);
    typedef struct packed {
        logic       asleep;
        logic       to;
        logic       pd;
        rst_cause_e cause;
        logic       bor_seen;
        logic       pin_seen;
    } stat_t;

    stat_t stat_q, stat_d;

    logic pin_low, slow_tick;
    logic bor_req, pin_req, wdt_req, any_req;
    logic bor_evt, pin_evt, wake;
    logic asleep_q;

    rsq_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_pin_filter (
        .clk_i     (osc_clk_i),
        .arst_i    (por_i),
        .pin_n_i   (ext_rst_n_i),
        .held_low_o(pin_low)
    );

    rsq_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_tick_sync (
        .clk_i     (osc_clk_i),
        .arst_i    (por_i),
        .slow_clk_i(wdt_osc_clk_i),
        .tick_o    (slow_tick)
    );

    rsq_timer_chain #(.PWRT_W(PWRT_W), .OST_W(OST_W)) u_timer_chain (
        .clk_i      (osc_clk_i),
        .arst_i     (por_i),
        .req_i      (any_req),
        .slow_tick_i(slow_tick),
        .pwrt_en_i  (pwrt_en_i),
        .ost_en_i   (ost_en_i),
        .chip_rst_o (chip_rst_o)
    );

    assign asleep_q = stat_q.asleep;
    assign bor_req  = bor_en_i & bor_detect_i;
    assign pin_req  = ext_rst_en_i & pin_low;
    assign wdt_req  = wdt_timeout_i & ~stat_q.asleep;
    assign any_req  = bor_req | pin_req | wdt_req;
    assign bor_evt  = bor_req & ~stat_q.bor_seen;
    assign pin_evt  = pin_req & ~stat_q.pin_seen;
    assign wake     = wdt_timeout_i & stat_q.asleep;

    always_comb begin
        stat_d          = stat_q;
        stat_d.bor_seen = bor_req;
        stat_d.pin_seen = pin_req;
        if (bor_evt) begin
            stat_d.to    = 1'b1;
            stat_d.pd    = 1'b1;
            stat_d.cause = CAUSE_BROWNOUT;
        end else if (wdt_req) begin
            stat_d.to    = 1'b0;
            stat_d.cause = CAUSE_WDOG_RUN;
        end else if (pin_evt) begin
            if (stat_q.asleep) begin
                stat_d.pd    = 1'b0;
                stat_d.cause = CAUSE_PIN_SLEEP;
            end else begin
                stat_d.cause = CAUSE_PIN_RUN;
            end
        end else if (wake) begin
            stat_d.to    = 1'b0;
            stat_d.pd    = 1'b0;
            stat_d.cause = CAUSE_WDOG_WAKE;
        end else if (sleep_enter_i && !chip_rst_o && !any_req && !stat_q.asleep) begin
            stat_d.asleep = 1'b1;
            stat_d.to     = 1'b1;
            stat_d.pd     = 1'b0;
        end
        if (any_req || wake) stat_d.asleep = 1'b0;
    end

    always_ff @(posedge osc_clk_i or posedge por_i) begin
        if (por_i) begin
            stat_q.asleep   <= 1'b0;
            stat_q.to       <= 1'b1;
            stat_q.pd       <= 1'b1;
            stat_q.cause    <= CAUSE_POWER_ON;
            stat_q.bor_seen <= 1'b0;
            stat_q.pin_seen <= 1'b0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign to_flag_o   = stat_q.to;
    assign pd_flag_o   = stat_q.pd;
    assign rst_cause_o = stat_q.cause;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker (
    input logic clk_i,
    input logic por_i,
    input logic chip_rst_i,
    input logic to_i,
    input logic pd_i,
    input logic any_req_i,
    input logic asleep_i,
    input logic wdt_i
);
    // R9
    req_holds_rst_chk: assert property (@(posedge clk_i) disable iff (por_i)
        any_req_i |=> chip_rst_i);

    // R7
    no_spurious_rst_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (!chip_rst_i && !any_req_i) |=> !chip_rst_i);

    // R7
    wake_flags_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (wdt_i && asleep_i && !any_req_i) |=> (!to_i && !pd_i && !asleep_i));

    // R8
    sleep_flags_chk: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(asleep_i) |-> (to_i && !pd_i));

    // R11
    reset_ends_sleep_chk: assert property (@(posedge clk_i) disable iff (por_i)
        any_req_i |=> !asleep_i);
endmodule

bind reset_sequencer rsq_checker u_rsq_checker (
    .clk_i     (osc_clk_i),
    .por_i     (por_i),
    .chip_rst_i(chip_rst_o),
    .to_i      (to_flag_o),
    .pd_i      (pd_flag_o),
    .any_req_i (any_req),
    .asleep_i  (asleep_q),
    .wdt_i     (wdt_timeout_i)
);

// File: tb/reset_sequencer_bench.sv
`timescale 1ns/1ps
module reset_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PW    = 3;
    localparam int OW    = 2;
    localparam int FL    = 4;
    localparam int SLOWP = 4;
    localparam int LIMIT = 20000;

    logic clk = 1'b0;
    logic wdt_clk = 1'b0;
    logic por = 1'b1, bor = 1'b0, bor_en = 1'b1, pin_n = 1'b1, pin_en = 1'b1;
    logic wdt = 1'b0, slp = 1'b0, pwrt_en = 1'b0, ost_en = 1'b0;
    logic chip_rst, to_f, pd_f;
    logic [2:0] cause;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int div = 0;
    logic saw = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        div = div + 1;
        if (div == SLOWP/2) begin
            div = 0;
            wdt_clk = ~wdt_clk;
        end
        if (chip_rst) saw = 1'b1;
    end

    reset_sequencer #(.PWRT_W(PW), .OST_W(OW), .FILT_LEN(FL), .SYNC_STAGES(2)) u_reset_sequencer (
        .osc_clk_i    (clk),
        .wdt_osc_clk_i(wdt_clk),
        .por_i        (por),
        .bor_detect_i (bor),
        .bor_en_i     (bor_en),
        .ext_rst_n_i  (pin_n),
        .ext_rst_en_i (pin_en),
        .wdt_timeout_i(wdt),
        .sleep_enter_i(slp),
        .pwrt_en_i    (pwrt_en),
        .ost_en_i     (ost_en),
        .chip_rst_o   (chip_rst),
        .to_flag_o    (to_f),
        .pd_flag_o    (pd_f),
        .rst_cause_o  (cause)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while (chip_rst && n < 5000);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic bor_pulse();
        @(negedge clk) bor = 1'b1;
        @(negedge clk) bor = 1'b0;
    endtask

    task automatic wdt_pulse();
        @(negedge clk) wdt = 1'b1;
        @(negedge clk) wdt = 1'b0;
        #1;
    endtask

    task automatic sleep_pulse();
        @(negedge clk) slp = 1'b1;
        @(negedge clk) slp = 1'b0;
        #1;
    endtask

    task automatic pin_press(input int len);
        @(negedge clk) pin_n = 1'b0;
        for (int i = 0; i < len; i++) @(negedge clk);
        pin_n = 1'b1;
        idle(12);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int exp_cause;
        idle(3); #1;
        chk("R1 rst during por", chip_rst, 1);
        chk("R1 to", to_f, 1);
        chk("R1 pd", pd_f, 1);
        chk("R1 cause", cause, 1);
        @(negedge clk) por = 1'b0;
        measure(n);
        chk("R9 release after por, no waits", n, 1);

        // R9 sweep over wait enables, R2 flags
        for (int c = 0; c < 4; c++) begin
            int lo, hi;
            pwrt_en = c[1];
            ost_en  = c[0];
            bor_pulse();
            #1;
            chk("R2 brown-out cause", cause, 2);
            chk("R2 brown-out flags", {to_f, pd_f}, 3);
            measure(n);
            lo = 1 + (c[0] ? (1 << OW) : 0);
            hi = lo;
            if (c[1]) begin
                lo = lo + ((1 << PW) - 1) * SLOWP;
                hi = hi + (1 << PW) * SLOWP + 1;
            end
            chk_rng("R9 release time", n, lo, hi);
            idle(2);
        end

        // R10 restart during oscillator wait
        pwrt_en = 1'b0; ost_en = 1'b1;
        bor_pulse();
        @(posedge clk); @(posedge clk); #1;
        chk("R10 still in reset mid-wait", chip_rst, 1);
        bor_pulse();
        measure(n);
        chk("R10 full wait after restart", n, 1 + (1 << OW));
        ost_en = 1'b0;
        idle(2);

        // R2 disabled
        bor_en = 1'b0; saw = 1'b0;
        @(negedge clk) bor = 1'b1;
        idle(4); bor = 1'b0; idle(3);
        chk("R2 disabled brown-out no reset", saw, 0);
        chk("R2 disabled cause kept", cause, 2);
        bor_en = 1'b1;

        // R6 watchdog while running
        wdt_pulse();
        chk("R6 watchdog reset", chip_rst, 1);
        chk("R6 to cleared", to_f, 0);
        chk("R6 pd kept", pd_f, 1);
        chk("R6 cause", cause, 3);
        idle(4);

        // R3 and R4 pin filter sweep
        exp_cause = 3;
        for (int len = 1; len <= 6; len++) begin
            saw = 1'b0;
            pin_press(len);
            if (len >= FL) exp_cause = 5;
            chk("R3 pin pulse length vs reset", saw, (len >= FL) ? 1 : 0);
            chk("R4 pin cause", cause, exp_cause);
            chk("R4 pin run flags unchanged", {to_f, pd_f}, 1);
        end
        pin_en = 1'b0; saw = 1'b0;
        pin_press(6);
        chk("R3 disabled pin no reset", saw, 0);
        pin_en = 1'b1;

        // R8 sleep entry, R7 wake
        saw = 1'b0;
        sleep_pulse();
        chk("R8 sleep flags", {to_f, pd_f}, 2);
        chk("R8 sleep no reset", saw, 0);
        wdt_pulse();
        idle(6);
        chk("R7 wake no reset", saw, 0);
        chk("R7 wake flags", {to_f, pd_f}, 0);
        chk("R7 wake cause", cause, 4);
        wdt_pulse();
        chk("R7 awake after wake, watchdog resets", chip_rst, 1);
        chk("R7 cause after second watchdog", cause, 3);
        idle(4);

        // R5 pin while asleep, R11 sleep ended by reset
        sleep_pulse();
        saw = 1'b0;
        pin_press(6);
        chk("R5 pin in sleep resets", saw, 1);
        chk("R5 cause", cause, 6);
        chk("R5 flags", {to_f, pd_f}, 2);
        wdt_pulse();
        chk("R11 watchdog after pin reset is a reset", chip_rst, 1);
        chk("R11 cause", cause, 3);
        idle(4);

        // R8 ignored while chip reset asserted
        ost_en = 1'b1;
        bor_pulse();
        sleep_pulse();
        chk("R8 sleep ignored in reset, pd", pd_f, 1);
        measure(n);
        ost_en = 1'b0;
        wdt_pulse();
        chk("R8 not asleep after ignored entry", cause, 3);
        chk("R8 reset taken", chip_rst, 1);
        idle(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule